// File: doc/BRIEF.md
# Scanline Sprite Line Buffer

This block holds the sprite pixels for one scanline of a tile-based display processor. While the horizontal blanking interval lasts, an upstream fetch stage presents decoded slivers of eight sprite pixels. Each sliver carries a 9-bit screen X position, a 2-bit priority, a 3-bit palette and an optional mirror flag. The block merges the sliver into a one-line store, and only opaque pixels that land on still-empty entries are kept. The whole line is therefore rendered once, and no sprite list is searched per pixel. Up to 32 slivers fit in a blanking interval.

During the next active line, the horizontal dot counter addresses the store. The block returns each sprite entry one cycle later, in step with the background stream, and empties the entry as it is consumed. This leaves the store blank for the next fill. When the background runs at double horizontal resolution, sprites keep single resolution: each entry is presented for two consecutive dots and cleared after the second one. A margin of seven hidden entries on each side takes pixels of slivers that hang over a screen edge, so no clipping logic is needed.

Top module: `sprite_line_buffer`

## Requirements
- R1: After reset every one of the 256 screen columns reads back as transparent (all nine entry bits zero), and `wr_accept` is low.
- R2: A sliver is held on the write inputs while `hblank` and `wr_valid` are high. The block takes it over two cycles and pulses `wr_accept` on the second cycle, so one sliver is accepted every two cycles.
- R3: Without mirroring, pixel j of a sliver is held in `wr_pix[4j+3:4j]` and is placed at screen column (`wr_x` + j) mod 512. Each entry reads out as priority, palette and colour index on `px_prio`, `px_pal` and `px_idx`.
- R4: A colour index of 0 is transparent. It never writes an entry, so a later opaque pixel can still fill that column.
- R5: Where slivers overlap, the first opaque pixel written to a column stays. Later slivers only fill columns that are still transparent.
- R6: With `wr_flip` high, pixel j is placed at column (`wr_x` + 7 − j) mod 512.
- R7: Positions 505..511 and 256..262 fall in hidden margin entries that are never displayed. Positions 263..504 are discarded. A sliver at X 509 shows its pixels 3..7 at columns 0..4.
- R8: The output appears one cycle after the dot is presented. While `active` is low, the outputs are all zero.
- R9: With `hires` low, column `dot_x[7:0]` is read and emptied in the same cycle, so a second read of that column in the same line returns transparent.
- R10: With `hires` high, column `dot_x[8:1]` is shown for both the even and the odd dot of the pair and is emptied only after the odd dot.
- R11: For random sets of up to 32 slivers, the streamed line matches the overlap and transparency rules, and a line read back afterwards with no new writes is fully transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hblank | input | 1 | Blanking interval, write window |
| active | input | 1 | Active display, read window |
| hires | input | 1 | Background at 512 dots per line |
| wr_valid | input | 1 | Sliver present on write inputs |
| wr_x | input | 9 | Sliver screen X, modulo 512 |
| wr_flip | input | 1 | Sliver horizontally mirrored |
| wr_prio | input | 2 | Sliver priority |
| wr_pal | input | 3 | Sliver palette select |
| wr_pix | input | 32 | Eight 4-bit colour indices, pixel j in bits 4j+3:4j |
| wr_accept | output | 1 | Sliver consumed this cycle |
| dot_x | input | 9 | Horizontal dot counter |
| px_prio | output | 2 | Sprite priority of current dot |
| px_pal | output | 3 | Sprite palette of current dot |
| px_idx | output | 4 | Sprite colour index, 0 means no sprite |

## Verification
The bench builds the block with its default parameters: 256 columns, a margin of 7 entries and 8-pixel slivers of 4-bit indices. With these values, both screen edges, the 512 wrap and the hidden margins can be reached with single slivers. A full line takes a few hundred cycles, so several complete fill-and-drain lines, in both horizontal resolutions, fit in a short run. The reference model keeps only the 256 visible columns, so any leak from the margins into the display shows up as a mismatch.

// File: rtl/sprite_line_buffer.sv
module sprite_line_buffer #(
  parameter int COLS   = 256,
  parameter int PAD    = 7,
  parameter int SLIVER = 8,
  parameter int IDX_W  = 4,
  parameter int PAL_W  = 3,
  parameter int PRI_W  = 2,
  parameter int X_W    = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hblank,
  input  logic                    active,
  input  logic                    hires,
  input  logic                    wr_valid,
  input  logic [X_W-1:0]          wr_x,
  input  logic                    wr_flip,
  input  logic [PRI_W-1:0]        wr_prio,
  input  logic [PAL_W-1:0]        wr_pal,
  input  logic [SLIVER*IDX_W-1:0] wr_pix,
  output logic                    wr_accept,
  input  logic [$clog2(COLS):0]   dot_x,
  output logic [PRI_W-1:0]        px_prio,
  output logic [PAL_W-1:0]        px_pal,
  output logic [IDX_W-1:0]        px_idx
);
  localparam int ENT_W = PRI_W + PAL_W + IDX_W;
  localparam int DEPTH = COLS + 2 * PAD;
  localparam int HALF  = SLIVER / 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int COL_W = $clog2(COLS);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] px_q;
  logic             phase;

  logic [AW-1:0]    lane_addr [HALF];
  logic             lane_ok   [HALF];
  logic [IDX_W-1:0] lane_pix  [HALF];

  wire              wr_go    = wr_valid & hblank;
  wire [COL_W-1:0]  rd_col   = hires ? dot_x[COL_W:1] : dot_x[COL_W-1:0];
  wire [AW-1:0]     rd_addr  = AW'(rd_col) + AW'(PAD);
  wire              rd_clear = active & (~hires | dot_x[0]);

  assign wr_accept = wr_go & phase;
  assign {px_prio, px_pal, px_idx} = px_q;

  for (genvar g = 0; g < HALF; g++) begin : g_lane
    logic [X_W-1:0] off, slot;
    logic [$clog2(SLIVER)-1:0] src;
    assign off  = phase ? X_W'(HALF + g) : X_W'(g);
    assign src  = wr_flip ? $clog2(SLIVER)'(SLIVER - 1 - int'(off)) : $clog2(SLIVER)'(off);
    assign slot = wr_x + off + X_W'(PAD);
    assign lane_pix[g]  = wr_pix[src*IDX_W +: IDX_W];
    assign lane_addr[g] = AW'(slot);
    assign lane_ok[g]   = (int'(slot) < DEPTH) && (lane_pix[g] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      px_q  <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      phase <= wr_go ? ~phase : 1'b0;
      if (wr_go) begin
        for (int g = 0; g < HALF; g++)
          if (lane_ok[g] && mem[lane_addr[g]][IDX_W-1:0] == '0)
            mem[lane_addr[g]] <= {wr_prio, wr_pal, lane_pix[g]};
      end
      if (active) begin
        px_q <= mem[rd_addr];
        if (rd_clear) mem[rd_addr] <= '0;
        for (int k = 0; k < PAD; k++) begin
          mem[k]            <= '0;
          mem[PAD+COLS+k]   <= '0;
        end
      end else begin
        px_q <= '0;
      end
    end
  end
endmodule

// File: rtl/sprite_line_buffer_chk.sv
module sprite_line_buffer_chk #(
  parameter int DX_W  = 9,
  parameter int IDX_W = 4,
  parameter int PAL_W = 3,
  parameter int PRI_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hblank,
  input logic             active,
  input logic             hires,
  input logic             wr_valid,
  input logic             wr_accept,
  input logic [DX_W-1:0]  dot_x,
  input logic [PRI_W-1:0] px_prio,
  input logic [PAL_W-1:0] px_pal,
  input logic [IDX_W-1:0] px_idx
);
  AST_ACCEPT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> $past(wr_valid && hblank)); // R2
  AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_accept); // R2
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (px_idx == '0 && px_pal == '0 && px_prio == '0)); // R8
  AST_REREAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hires && $past(active && !hires) && dot_x == $past(dot_x)) |=> px_idx == '0); // R9
  AST_HIRES_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hires && dot_x[0] && $past(active && hires && !dot_x[0])
     && dot_x[DX_W-1:1] == $past(dot_x[DX_W-1:1]))
    |=> {px_prio, px_pal, px_idx} == $past({px_prio, px_pal, px_idx})); // R10
endmodule

bind sprite_line_buffer sprite_line_buffer_chk #(
  .DX_W(COL_W + 1), .IDX_W(IDX_W), .PAL_W(PAL_W), .PRI_W(PRI_W)
) chk_i (.*);

// File: tb/sprite_line_buffer_tb_top.sv
module sprite_line_buffer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hblank = 1'b0, active = 1'b0, hires = 1'b0;
  logic wr_valid = 1'b0, wr_flip = 1'b0;
  logic [8:0]  wr_x = '0;
  logic [1:0]  wr_prio = '0;
  logic [2:0]  wr_pal = '0;
  logic [31:0] wr_pix = '0;
  logic        wr_accept;
  logic [8:0]  dot_x = '0;
  logic [1:0]  px_prio;
  logic [2:0]  px_pal;
  logic [3:0]  px_idx;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [8:0] model [256];

  always #4 clk = ~clk;

  sprite_line_buffer dut_i (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < 256; c++) model[c] = '0;
  endtask

  task automatic put(logic [8:0] x, bit flip, logic [1:0] pr, logic [2:0] pl, logic [31:0] pix);
    @(negedge clk);
    hblank = 1'b1; wr_valid = 1'b1;
    wr_x = x; wr_flip = flip; wr_prio = pr; wr_pal = pl; wr_pix = pix;
    @(posedge clk); #1;
    check("R2 accept on second cycle", wr_accept, 1);
    @(posedge clk); #1;
    check("R2 idle after accept", wr_accept, 0);
    for (int j = 0; j < 8; j++) begin
      logic [8:0] col;
      logic [3:0] p;
      p   = pix[4*j +: 4];
      col = x + 9'(flip ? 7 - j : j);
      if (col < 256 && p != 0 && model[col[7:0]][3:0] == 0)
        model[col[7:0]] = {pr, pl, p};
    end
  endtask

  task automatic end_fill();
    @(negedge clk);
    wr_valid = 1'b0; hblank = 1'b0;
  endtask

  task automatic read_line(string tag, bit hi);
    int n;
    n = hi ? 512 : 256;
    for (int d = 0; d < n; d++) begin
      @(negedge clk);
      active = 1'b1; hires = hi; dot_x = 9'(d);
      @(posedge clk); #1;
      check(tag, {px_prio, px_pal, px_idx}, model[hi ? d / 2 : d]);
    end
    @(negedge clk);
    active = 1'b0; hires = 1'b0;
    clear_model();
  endtask

  task automatic t_reset();
    check("R1 accept low", wr_accept, 0);
    clear_model();
    read_line("R1 empty after reset", 0);
  endtask

  task automatic t_place();
    put(9'd20, 0, 2'd2, 3'd5, 32'h8765_4321);
    end_fill();
    read_line("R3 placement", 0);
  endtask

  task automatic t_transp();
    put(9'd40, 0, 2'd1, 3'd1, 32'h0A0B_00C0);
    put(9'd40, 0, 2'd3, 3'd6, 32'h1111_1111);
    end_fill();
    check("R4 hole filled by later", model[40], {2'd3, 3'd6, 4'd1});
    read_line("R4 transparency", 0);
  endtask

  task automatic t_overlap();
    put(9'd100, 0, 2'd0, 3'd2, 32'h2222_2222);
    put(9'd104, 0, 2'd3, 3'd7, 32'h3333_3333);
    end_fill();
    check("R5 first wins", model[105], {2'd0, 3'd2, 4'd2});
    read_line("R5 overlap", 0);
  endtask

  task automatic t_flip();
    put(9'd60, 1, 2'd1, 3'd3, 32'h8765_4321);
    end_fill();
    check("R6 mirrored first column", model[60], {2'd1, 3'd3, 4'd8});
    read_line("R6 flip", 0);
  endtask

  task automatic t_wrap();
    put(9'd509, 0, 2'd2, 3'd4, 32'h8765_4321);
    put(9'd252, 0, 2'd1, 3'd1, 32'h9999_9999);
    put(9'd300, 0, 2'd3, 3'd7, 32'hFFFF_FFFF);
    end_fill();
    check("R7 wrapped pixel 3 at column 0", model[0], {2'd2, 3'd4, 4'd4});
    read_line("R7 edges and wrap", 0);
    put(9'd505, 0, 2'd0, 3'd1, 32'h5000_0000);
    end_fill();
    read_line("R7 margin reused next line", 0);
  endtask

  task automatic t_idle();
    put(9'd8, 0, 2'd3, 3'd7, 32'hFFFF_FFFF);
    end_fill();
    repeat (3) @(posedge clk);
    #1;
    check("R8 dark when inactive", {px_prio, px_pal, px_idx}, 0);
    read_line("R8 latency one cycle", 0);
  endtask

  task automatic t_reread();
    put(9'd10, 0, 2'd1, 3'd2, 32'h0000_0007);
    end_fill();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      active = 1'b1; hires = 1'b0; dot_x = 9'd10;
      @(posedge clk); #1;
      check(k == 0 ? "R9 first read" : "R9 second read cleared",
            {px_prio, px_pal, px_idx}, k == 0 ? {2'd1, 3'd2, 4'd7} : 9'd0);
    end
    @(negedge clk); active = 1'b0;
    clear_model();
    read_line("R9 line empty after read", 0);
  endtask

  task automatic t_hires();
    put(9'd0, 0, 2'd2, 3'd3, 32'h1234_5678);
    put(9'd250, 1, 2'd1, 3'd6, 32'hABCD_EF12);
    end_fill();
    read_line("R10 double width", 1);
    read_line("R10 cleared after pair", 1);
  endtask

  task automatic t_random();
    for (int line = 0; line < 4; line++) begin
      int n;
      n = 1 + int'($urandom % 32);
      for (int s = 0; s < n; s++)
        put(9'($urandom), 1'($urandom), 2'($urandom), 3'($urandom), $urandom & $urandom);
      end_fill();
      read_line("R11 random line", line[0]);
      read_line("R11 empty after line", 0);
    end
  endtask

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_place();
    t_transp();
    t_overlap();
    t_flip();
    t_wrap();
    t_idle();
    t_reread();
    t_hires();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule